// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Instruction-Boundary Sampling

This block decides when a small microcontroller core must stop its normal instruction stream and perform a hardware subroutine call into an interrupt handler. It gathers thirteen interrupt sources. Four of them are built by OR-ing several peripheral flags together. Each source has a per-source enable and a two-bit priority level, and a global enable applies on top of those. The source-zero request (reset) ignores both the per-source enables and the global enable.

Request flags pass through one register stage. The arbiter looks at them only when the core reports the final cycle of an instruction. At such a boundary the highest-priority eligible source wins, and ties go to the lower source number. The winner is accepted only if all of the following hold:

- no equal or higher level is already being serviced;
- the finishing instruction is not a return-from-interrupt;
- the finishing instruction is not a write to the enable or priority configuration;
- the core is not held in forced idle.

When a source is accepted, the block starts a four-cycle call sequence and presents the handler address. A request that is refused is not remembered.

The core drives the boundary, return and configuration-write indications. It uses `call_req`, `call_step` and `call_vector` to push the return address and load the program counter.

Top module: `irq_ctrl`

## Requirements
- R1: Requests are taken only at a clock edge where `instr_last` is 1. The value used is the flag value registered one edge earlier. A flag first raised in the cycle where `instr_last` is 1 is not accepted at that boundary, and it is accepted at a later boundary if it is still high.
- R2: The priority level of source i is {`prio_hi[i]`, `prio_lo[i]`}, where 3 is the highest level. Among eligible sources the highest level wins, and between equal levels the lower source number wins.
- R3: A winner is refused while its level, or any higher level, is in service. A winner with a level strictly above every level in service is accepted, so handlers can nest.
- R4: No call is accepted at a boundary where `instr_is_reti` or `instr_is_cfg_wr` is 1.
- R5: No call is accepted while `forced_idle` is 1.
- R6: After an accepted boundary edge, `call_step` is one-hot for four consecutive cycles, going through bits 0, 1, 2 and 3 in that order. `call_req` is 1 only in the first of those cycles, and `call_vector` holds the handler address throughout. `instr_last` is ignored during these four cycles.
- R7: Source numbers and handler addresses are: 0 reset 0000h, 1 external 0, 2 timer 0, 3 external 1, 4 timer 1, 5 serial, 6 timer 2, 7 comparator, 8 general-purpose input, 9 compare/capture, 10 SPI, 11 ADC, 12 two-wire. For source i ≥ 1 the address is 8·i − 5, which runs from 0003h to 005Bh.
- R8: Four sources are ORs of several flags:
  - serial = `ser_rx_flag` | `ser_tx_flag`;
  - timer 2 = `tmr2_ovf_flag` | `tmr2_ext_flag`;
  - comparator = `cmp_a_flag` | `cmp_b_flag`;
  - SPI = `spi_done_flag` | `spi_fault_flag` | `spi_txe_flag`.
- R9: Nothing is remembered after a refusal. If a request is refused and then goes low before the next boundary, it produces no call.
- R10: Source i ≥ 1 is eligible only when both `src_en[i]` and `global_en` are 1. Source 0 (`rst_req`) is eligible regardless of either enable.
- R11: There is one in-service bit per level. Acceptance sets the bit for the winner's level. A boundary with `instr_is_reti` set clears the highest set bit.
- R12: After reset, `call_req` is 0, `call_step` is 0, `call_vector` is 0000h, and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Source 0 request (reset) |
| ext0_flag | input | 1 | External request 0 |
| tmr0_flag | input | 1 | Timer 0 overflow |
| ext1_flag | input | 1 | External request 1 |
| tmr1_flag | input | 1 | Timer 1 overflow |
| ser_rx_flag | input | 1 | Serial receive done |
| ser_tx_flag | input | 1 | Serial transmit done |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow |
| tmr2_ext_flag | input | 1 | Timer 2 external event |
| cmp_a_flag | input | 1 | Comparator channel A |
| cmp_b_flag | input | 1 | Comparator channel B |
| gpin_flag | input | 1 | General-purpose input event |
| ccap_flag | input | 1 | Compare/capture event |
| spi_done_flag | input | 1 | SPI transfer done |
| spi_fault_flag | input | 1 | SPI mode fault |
| spi_txe_flag | input | 1 | SPI transmit buffer empty |
| adc_flag | input | 1 | ADC conversion done |
| twi_flag | input | 1 | Two-wire interface event |
| src_en | input | 12 | Per-source enables for sources 12..1 |
| global_en | input | 1 | Global enable for sources 1..12 |
| prio_hi | input | 13 | Priority high bit per source |
| prio_lo | input | 13 | Priority low bit per source |
| instr_last | input | 1 | Final cycle of the current instruction |
| instr_is_reti | input | 1 | Finishing instruction is a return-from-interrupt |
| instr_is_cfg_wr | input | 1 | Finishing instruction writes enable or priority configuration |
| forced_idle | input | 1 | Core held idle by a nonvolatile memory write |
| call_req | output | 1 | One-cycle pulse at the start of a hardware call |
| call_step | output | 4 | One-hot step of the four-cycle call sequence |
| call_vector | output | 16 | Handler address |

## Verification
The hardest situation to reach is a sequence of nested and then unwound service levels. In that sequence, acceptance depends on in-service state that the ports do not show directly. The bench builds this state by accepting a low-level source and then accepting a higher-level one. It then returns from the higher level and offers a same-level competitor, which must stay blocked until a second return clears the lower level. Two further cases rely on exact cycle placement of the stimulus: a flag raised in the boundary cycle itself, and a higher-priority request presented during the four call cycles with `instr_last` high.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC  = 13;
    localparam int LVL_W    = 2;
    localparam int NUM_LVL  = 1 << LVL_W;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int VEC_W    = 16;
    localparam int CALL_LEN = 4;
    localparam int VEC_STEP = 8;
    localparam int VEC_OFS  = 5;

    localparam int SRC_RST  = 0;
    localparam int SRC_EXT0 = 1;
    localparam int SRC_TMR0 = 2;
    localparam int SRC_EXT1 = 3;
    localparam int SRC_TMR1 = 4;
    localparam int SRC_SER  = 5;
    localparam int SRC_TMR2 = 6;
    localparam int SRC_CMP  = 7;
    localparam int SRC_GPIN = 8;
    localparam int SRC_CCAP = 9;
    localparam int SRC_SPI  = 10;
    localparam int SRC_ADC  = 11;
    localparam int SRC_TWI  = 12;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [SRC_W-1:0] src_idx_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
        lvl_t     lvl;
    } pick_t;

    // handler address: source 0 at zero, others spaced eight bytes apart
    function automatic vec_t vec_of(src_idx_t i);
        if (i == src_idx_t'(SRC_RST))
            return '0;
        return (vec_t'(i) * vec_t'(VEC_STEP)) - vec_t'(VEC_OFS);
    endfunction
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_req,
    input  logic               ext0_flag,
    input  logic               tmr0_flag,
    input  logic               ext1_flag,
    input  logic               tmr1_flag,
    input  logic               ser_rx_flag,
    input  logic               ser_tx_flag,
    input  logic               tmr2_ovf_flag,
    input  logic               tmr2_ext_flag,
    input  logic               cmp_a_flag,
    input  logic               cmp_b_flag,
    input  logic               gpin_flag,
    input  logic               ccap_flag,
    input  logic               spi_done_flag,
    input  logic               spi_fault_flag,
    input  logic               spi_txe_flag,
    input  logic               adc_flag,
    input  logic               twi_flag,
    output logic [NUM_SRC-1:0] req_dly
);
    logic [NUM_SRC-1:0] req_now;

    always_comb begin
        req_now           = '0;
        req_now[SRC_RST]  = rst_req;
        req_now[SRC_EXT0] = ext0_flag;
        req_now[SRC_TMR0] = tmr0_flag;
        req_now[SRC_EXT1] = ext1_flag;
        req_now[SRC_TMR1] = tmr1_flag;
        req_now[SRC_SER]  = ser_rx_flag | ser_tx_flag;
        req_now[SRC_TMR2] = tmr2_ovf_flag | tmr2_ext_flag;
        req_now[SRC_CMP]  = cmp_a_flag | cmp_b_flag;
        req_now[SRC_GPIN] = gpin_flag;
        req_now[SRC_CCAP] = ccap_flag;
        req_now[SRC_SPI]  = spi_done_flag | spi_fault_flag | spi_txe_flag;
        req_now[SRC_ADC]  = adc_flag;
        req_now[SRC_TWI]  = twi_flag;
    end

    // one-cycle delay: boundary decisions see the previous cycle's flags
    always_ff @(posedge clk) begin
        if (rst) req_dly <= '0;
        else     req_dly <= req_now;
    end

    // R1: the delayed vector follows the combined flags by exactly one edge
    p_delay_one_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> req_dly == $past(req_now));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:1] src_en,
    input  logic               global_en,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    output pick_t              pick
);
    logic [NUM_SRC-1:0] elig;
    lvl_t               lvl [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign lvl[g] = {prio_hi[g], prio_lo[g]};
        if (g == SRC_RST) begin : g_nonmask
            assign elig[g] = req[g];
        end else begin : g_mask
            assign elig[g] = req[g] & src_en[g] & global_en;
        end
    end

    // strictly-greater replacement keeps the lowest index on a tie
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!pick.valid || lvl[i] > pick.lvl)) begin
                pick.valid = 1'b1;
                pick.idx   = src_idx_t'(i);
                pick.lvl   = lvl[i];
            end
        end
    end

    // R2: a valid pick always names an eligible source at its own level
    always_comb begin
        if (pick.valid) begin
            a_pick_elig_r2: assert (elig[pick.idx] && lvl[pick.idx] == pick.lvl);
        end
    end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  lvl_t set_lvl,
    input  logic ret_en,
    output logic any_busy,
    output lvl_t top_lvl
);
    logic [NUM_LVL-1:0] ins;
    logic [NUM_LVL-1:0] clr_mask;

    always_comb begin
        top_lvl  = '0;
        clr_mask = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (ins[l]) top_lvl = lvl_t'(l);
        end
        clr_mask[top_lvl] = |ins;
    end

    always_ff @(posedge clk) begin
        if (rst)         ins <= '0;
        else if (set_en) ins <= ins | (NUM_LVL'(1) << set_lvl);
        else if (ret_en) ins <= ins & ~clr_mask;
    end

    assign any_busy = |ins;

    // R11: a return with something in service drops exactly one level
    p_ret_pops_one_r11: assert property (@(posedge clk) disable iff (rst)
        (ret_en && !set_en && any_busy) |=> $countones(ins) == $countones($past(ins)) - 1);

    // R3: a new level is only ever added above every level already in service
    p_nest_above_r3: assert property (@(posedge clk) disable iff (rst)
        set_en |-> (!any_busy || set_lvl > top_lvl));
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  vec_t                vec_in,
    output logic                busy,
    output logic [CALL_LEN-1:0] step,
    output vec_t                vec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= '0;
            vec_q <= '0;
        end else begin
            step <= {step[CALL_LEN-2:0], start};
            if (start) vec_q <= vec_in;
        end
    end

    assign busy = |step;

    // R6: call steps never overlap
    p_step_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step));

    // R6: each step hands over to the next one
    p_step_walk_r6: assert property (@(posedge clk) disable iff (rst)
        (step[CALL_LEN-2:0] != '0) |=> step[CALL_LEN-1:1] == $past(step[CALL_LEN-2:0]));

    // R6: the handler address stays put through the call
    p_vec_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !step[CALL_LEN-1]) |=> $stable(vec_q));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rst_req,
    input  logic                ext0_flag,
    input  logic                tmr0_flag,
    input  logic                ext1_flag,
    input  logic                tmr1_flag,
    input  logic                ser_rx_flag,
    input  logic                ser_tx_flag,
    input  logic                tmr2_ovf_flag,
    input  logic                tmr2_ext_flag,
    input  logic                cmp_a_flag,
    input  logic                cmp_b_flag,
    input  logic                gpin_flag,
    input  logic                ccap_flag,
    input  logic                spi_done_flag,
    input  logic                spi_fault_flag,
    input  logic                spi_txe_flag,
    input  logic                adc_flag,
    input  logic                twi_flag,
    input  logic [NUM_SRC-1:1]  src_en,
    input  logic                global_en,
    input  logic [NUM_SRC-1:0]  prio_hi,
    input  logic [NUM_SRC-1:0]  prio_lo,
    input  logic                instr_last,
    input  logic                instr_is_reti,
    input  logic                instr_is_cfg_wr,
    input  logic                forced_idle,
    output logic                call_req,
    output logic [CALL_LEN-1:0] call_step,
    output logic [VEC_W-1:0]    call_vector
);
    logic [NUM_SRC-1:0] req_dly;
    pick_t              pick;
    logic               busy;
    logic               lvl_busy;
    lvl_t               lvl_top;
    logic               boundary;
    logic               veto;
    logic               accept;
    logic               ret_done;

    irq_src_merge u_merge (
        .clk            (clk),
        .rst            (rst),
        .rst_req        (rst_req),
        .ext0_flag      (ext0_flag),
        .tmr0_flag      (tmr0_flag),
        .ext1_flag      (ext1_flag),
        .tmr1_flag      (tmr1_flag),
        .ser_rx_flag    (ser_rx_flag),
        .ser_tx_flag    (ser_tx_flag),
        .tmr2_ovf_flag  (tmr2_ovf_flag),
        .tmr2_ext_flag  (tmr2_ext_flag),
        .cmp_a_flag     (cmp_a_flag),
        .cmp_b_flag     (cmp_b_flag),
        .gpin_flag      (gpin_flag),
        .ccap_flag      (ccap_flag),
        .spi_done_flag  (spi_done_flag),
        .spi_fault_flag (spi_fault_flag),
        .spi_txe_flag   (spi_txe_flag),
        .adc_flag       (adc_flag),
        .twi_flag       (twi_flag),
        .req_dly        (req_dly)
    );

    irq_arbiter u_arb (
        .req       (req_dly),
        .src_en    (src_en),
        .global_en (global_en),
        .prio_hi   (prio_hi),
        .prio_lo   (prio_lo),
        .pick      (pick)
    );

    // the call sequence owns the core, so its cycles are not boundaries
    assign boundary = instr_last & ~busy;
    assign veto     = instr_is_reti | instr_is_cfg_wr | forced_idle
                    | (lvl_busy & (pick.lvl <= lvl_top));
    assign accept   = boundary & pick.valid & ~veto;
    assign ret_done = boundary & instr_is_reti;

    irq_level_track u_lvl (
        .clk      (clk),
        .rst      (rst),
        .set_en   (accept),
        .set_lvl  (pick.lvl),
        .ret_en   (ret_done),
        .any_busy (lvl_busy),
        .top_lvl  (lvl_top)
    );

    irq_call_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .vec_in (vec_of(pick.idx)),
        .busy   (busy),
        .step   (call_step),
        .vec_q  (call_vector)
    );

    assign call_req = call_step[0];

    // R1: a call only starts right after a boundary cycle
    p_at_boundary_r1: assert property (@(posedge clk) disable iff (rst)
        call_req |-> $past(instr_last));

    // R4: return or configuration write at the boundary suppresses a call
    p_no_call_after_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_last && (instr_is_reti || instr_is_cfg_wr)) |=> !call_req);

    // R5: forced idle suppresses a call
    p_no_call_idle_r5: assert property (@(posedge clk) disable iff (rst)
        forced_idle |=> !call_req);

    // R10: with the global enable low only source 0 may raise a call
    p_glob_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (!global_en && !req_dly[SRC_RST]) |=> !call_req);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [17:0] raw;
    logic [12:1] src_en;
    logic        global_en;
    logic [12:0] prio_hi, prio_lo;
    logic        il, reti, cfg, idle;
    logic        call_req;
    logic [3:0]  call_step;
    logic [15:0] call_vector;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .rst_req(raw[0]), .ext0_flag(raw[1]), .tmr0_flag(raw[2]),
        .ext1_flag(raw[3]), .tmr1_flag(raw[4]), .ser_rx_flag(raw[5]),
        .ser_tx_flag(raw[6]), .tmr2_ovf_flag(raw[7]), .tmr2_ext_flag(raw[8]),
        .cmp_a_flag(raw[9]), .cmp_b_flag(raw[10]), .gpin_flag(raw[11]),
        .ccap_flag(raw[12]), .spi_done_flag(raw[13]), .spi_fault_flag(raw[14]),
        .spi_txe_flag(raw[15]), .adc_flag(raw[16]), .twi_flag(raw[17]),
        .src_en(src_en), .global_en(global_en),
        .prio_hi(prio_hi), .prio_lo(prio_lo),
        .instr_last(il), .instr_is_reti(reti), .instr_is_cfg_wr(cfg),
        .forced_idle(idle),
        .call_req(call_req), .call_step(call_step), .call_vector(call_vector)
    );

    // primary flag bit used to raise each source number
    function automatic int flag_of(int s);
        case (s)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;
            4: return 4;   5: return 5;   6: return 7;   7: return 9;
            8: return 11;  9: return 12;  10: return 13; 11: return 16;
            default: return 17;
        endcase
    endfunction

    function automatic logic [15:0] exp_vec(int s);
        return (s == 0) ? 16'h0000 : 16'(s * 8 - 5);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; raw = '0; src_en = '1; global_en = 1'b1;
        prio_hi = '0; prio_lo = '0; il = 0; reti = 0; cfg = 0; idle = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic boundary(bit r, bit c, bit i);
        il = 1'b1; reti = r; cfg = c; idle = i;
        tick();
        il = 1'b0; reti = 1'b0; cfg = 1'b0; idle = 1'b0;
    endtask

    task automatic expect_call(string tag, logic [15:0] v);
        chk(call_req === 1'b1, tag, 32'(call_req), 32'd1);
        chk(call_vector === v, tag, 32'(call_vector), 32'(v));
        repeat (3) tick();
        tick();
    endtask

    task automatic expect_none(string tag);
        chk(call_req === 1'b0, tag, 32'(call_req), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(call_req === 1'b0, "R12 call_req", 32'(call_req), 0);
        chk(call_step === 4'b0, "R12 call_step", 32'(call_step), 0);
        chk(call_vector === 16'h0, "R12 call_vector", 32'(call_vector), 0);
        raw[SRC_ONE] = 1'b0;
        boundary(0, 0, 0);
        expect_none("R12 idle boundary");
    endtask
    localparam int SRC_ONE = 1;

    task automatic t_delay();
        do_reset();
        raw[1] = 1'b1;
        boundary(0, 0, 0);
        expect_none("R1 flag raised in boundary cycle");
        boundary(0, 0, 0);
        expect_call("R1 later boundary", 16'h0003);
    endtask

    task automatic t_vectors();
        for (int s = 0; s < 13; s++) begin
            do_reset();
            raw[flag_of(s)] = 1'b1;
            tick();
            boundary(0, 0, 0);
            expect_call($sformatf("R7 source %0d", s), exp_vec(s));
        end
    endtask

    task automatic t_merge();
        int bits [5] = '{6, 8, 10, 14, 15};
        logic [15:0] vecs [5] = '{16'h0023, 16'h002B, 16'h0033, 16'h004B, 16'h004B};
        for (int k = 0; k < 5; k++) begin
            do_reset();
            raw[bits[k]] = 1'b1;
            tick();
            boundary(0, 0, 0);
            expect_call($sformatf("R8 flag bit %0d", bits[k]), vecs[k]);
        end
    endtask

    task automatic t_prio();
        do_reset();
        prio_hi[12] = 1'b1; prio_lo[12] = 1'b1;
        raw[1] = 1'b1; raw[17] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R2 level 3 beats level 0", 16'h005B);
        do_reset();
        prio_hi[3] = 1'b1; prio_hi[4] = 1'b1;
        raw[3] = 1'b1; raw[4] = 1'b1; raw[16] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R2 tie to lower source", 16'h0013);
    endtask

    task automatic t_nest();
        do_reset();
        prio_lo[1] = 1'b1; prio_lo[3] = 1'b1; prio_hi[4] = 1'b1;
        raw[1] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R3 first level 1", 16'h0003);
        raw[1] = 1'b0; raw[3] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_none("R3 equal level blocked");
        raw[4] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R3 higher level nests", 16'h001B);
        raw[4] = 1'b0;
        tick();
        boundary(1, 0, 0);
        expect_none("R4 return boundary");
        boundary(0, 0, 0);
        expect_none("R11 level 1 still in service");
        boundary(1, 0, 0);
        expect_none("R4 second return");
        boundary(0, 0, 0);
        expect_call("R11 level 1 released", 16'h0013);
    endtask

    task automatic t_block();
        do_reset();
        raw[1] = 1'b1;
        tick();
        boundary(0, 1, 0);
        expect_none("R4 config write");
        boundary(0, 0, 1);
        expect_none("R5 forced idle");
        boundary(1, 0, 0);
        expect_none("R4 return with nothing in service");
        raw[1] = 1'b0;
        tick(); tick();
        boundary(0, 0, 0);
        expect_none("R9 refused request forgotten");
        raw[2] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R9 fresh request served", 16'h000B);
    endtask

    task automatic t_enable();
        do_reset();
        global_en = 1'b0;
        raw[1] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_none("R10 global enable low");
        global_en = 1'b1; src_en[1] = 1'b0;
        tick();
        boundary(0, 0, 0);
        expect_none("R10 source enable low");
        global_en = 1'b0; raw[0] = 1'b1;
        tick();
        boundary(0, 0, 0);
        expect_call("R10 reset source ignores enables", 16'h0000);
    endtask

    task automatic t_seq();
        do_reset();
        raw[2] = 1'b1;
        tick();
        boundary(0, 0, 0);
        chk(call_step === 4'b0001, "R6 step 0", 32'(call_step), 32'h1);
        chk(call_req === 1'b1, "R6 pulse", 32'(call_req), 1);
        chk(call_vector === 16'h000B, "R6 vector", 32'(call_vector), 32'h0B);
        raw[2] = 1'b0; raw[17] = 1'b1; prio_hi[12] = 1'b1; prio_lo[12] = 1'b1;
        for (int k = 1; k < 4; k++) begin
            il = 1'b1;
            tick();
            chk(call_step === 4'(1 << k), $sformatf("R6 step %0d", k), 32'(call_step), 32'(1 << k));
            chk(call_req === 1'b0, "R6 pulse only first cycle", 32'(call_req), 0);
            chk(call_vector === 16'h000B, "R6 vector held", 32'(call_vector), 32'h0B);
        end
        il = 1'b0;
        tick();
        chk(call_step === 4'b0, "R6 sequence over, boundary ignored", 32'(call_step), 0);
        boundary(0, 0, 0);
        expect_call("R6 deferred request after call", 16'h005B);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_delay();
        t_vectors();
        t_merge();
        t_prio();
        t_nest();
        t_block();
        t_enable();
        t_seq();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule